// File: doc/BRIEF.md
# Colour Matrix Coefficient Loader

This block takes the nine coefficients of a 3×3 colour-transform matrix, one per write. Each arrives as a 64-bit sign-magnitude number with 32 fractional bits. The block turns each one into a 15-bit two's-complement value with 12 fractional bits, which covers the range -4.0 to just under +4.0, and rejects any value that cannot be represented. Coefficients that convert cleanly go into a pending bank. A commit copies the whole pending bank into the active bank in one step. The nine active entries are driven out in parallel to the pixel datapath.

Software opens a batch with `batch_start`, writes the coefficients it wants to change, and then pulses `commit`. A bad coefficient or an out-of-range index raises a sticky error flag. While that flag is set, the commit is refused and the active bank keeps its old values. The flag clears only when the next batch opens. Entries that a batch does not write keep their earlier pending values.

A four-state machine controls the sequence:
- **IDLE**: no batch is open.
- **LOAD**: a batch is open and accepts writes.
- **APPLY**: a one-cycle state that copies pending to active.
- **REFUSE**: a one-cycle state entered on a commit while the error flag is set.

The transitions are:
- **open**: IDLE or LOAD to LOAD, on `batch_start`.
- **accept**: LOAD to APPLY, on `commit` with the error flag clear.
- **reject**: LOAD to REFUSE, on `commit` with the error flag set.
- **settle**: APPLY or REFUSE to IDLE, unconditionally.

Top module: `ctm_coeff_loader`

## Requirements
- R1: After reset all nine active entries are 0, `err_flag` is 0 and no batch is open.
- R2: The unsigned 15-bit candidate is input bits 34:20. The fractional bits 19:0 are truncated, not rounded. Magnitude bits 62:35 are discarded without any error.
- R3: When input bit 63 (the sign) is 1, the stored value is the 15-bit two's-complement negation of the candidate.
- R4: A coefficient is rejected exactly when the input sign differs from bit 14 of the converted value. For example, -4.0 (result 0x4000) and -2.0 (result 0x6000) are accepted. +4.0 is rejected. A negative input whose candidate is 0 is also rejected.
- R5: A rejected coefficient leaves the pending bank unchanged and sets `err_flag`. The flag stays set until the next batch opens.
- R6: A write with index 9 to 15 leaves the pending bank unchanged and sets `err_flag`. Entry i occupies `active_coeffs[15*i+14:15*i]`.
- R7: A write made while no batch is open has no effect.
- R8: A commit with `err_flag` clear updates all nine active entries together at the second rising edge after the commit is sampled. The active bank changes at no other time.
- R9: A commit with `err_flag` set leaves the active bank unchanged and keeps `err_flag` set.
- R10: `batch_start` in IDLE or LOAD opens a batch and clears `err_flag` at that edge. Pending entries keep their values.
- R11: In LOAD, `batch_start` takes priority over `commit`, and `commit` takes priority over a write. A write sampled in the same cycle as either of them is dropped.
- R12: Every input is ignored during the single cycle spent in APPLY or REFUSE. After that cycle the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| batch_start | input | 1 | Opens a batch and clears the error flag |
| commit | input | 1 | Requests the pending-to-active copy |
| wr_en | input | 1 | Coefficient write strobe |
| wr_idx | input | 4 | Coefficient index, 0 to 8 are valid |
| wr_data | input | 64 | Sign-magnitude coefficient, 32 fractional bits |
| active_coeffs | output | 135 | Nine 15-bit active coefficients, entry 0 in the low bits |
| err_flag | output | 1 | Sticky error flag for the current batch |

## Verification
- **Writes, batch opens and refused commits**: these act at the first rising edge after they are sampled. A write appears in `err_flag` at that edge. Its stored value becomes visible only through a later accepted commit.
- **Accepted commits**: the active bank changes at the second edge, because the machine passes through APPLY first.
- **Scoreboard timing**: the driver runs a cycle-level model of these rules. On every cycle it queues the expected active bank and error flag, tagged with the cycle in which they are due. The monitor compares them at the falling edge of exactly that cycle.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    localparam int unsigned CTM_COEF_CNT  = 9;
    localparam int unsigned CTM_IN_W      = 64;
    localparam int unsigned CTM_OUT_W     = 15;
    localparam int unsigned CTM_DROP_BITS = 20;
    localparam int unsigned CTM_IDX_W     = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_APPLY  = 2'd2,
        ST_REFUSE = 2'd3
    } ctm_state_e;

endpackage

// File: rtl/ctm_q_convert.sv
module ctm_q_convert #(
    parameter int unsigned IN_W      = 64,
    parameter int unsigned OUT_W     = 15,
    parameter int unsigned DROP_BITS = 20
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] q_val,
    output logic             q_ovf
);

    localparam int unsigned SIGN_POS = IN_W - 1;
    localparam int unsigned CAND_MSB = DROP_BITS + OUT_W - 1;

    logic             sign_bit;
    logic [OUT_W-1:0] cand;
    logic [OUT_W-1:0] cand_neg;

    // truncating slice: low fraction bits and high magnitude bits both fall away
    assign sign_bit = raw[SIGN_POS];
    assign cand     = raw[CAND_MSB:DROP_BITS];
    assign cand_neg = (~cand) + OUT_W'(1);

    always_comb begin
        q_val = sign_bit ? cand_neg : cand;
        // range test only after negation, so the most negative code survives
        q_ovf = (sign_bit != q_val[OUT_W-1]);
    end

    always_comb begin
        if (CAND_MSB >= SIGN_POS) begin
            a_slice_below_sign_r2 : assert (1'b0)
                else $error("candidate slice overlaps sign bit");
        end
    end

endmodule

// File: rtl/ctm_seq_ctrl.sv
module ctm_seq_ctrl
    import ctm_pkg::*;
#(
    parameter int unsigned COEF_CNT = 9,
    parameter int unsigned IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             batch_start,
    input  logic             commit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             conv_ovf,
    output logic             wr_accept,
    output logic             do_apply,
    output logic             err_flag
);

    ctm_state_e state_q;
    ctm_state_e state_d;
    logic       err_q;
    logic       idx_ok;
    logic       batch_wr;
    logic       open_req;

    assign idx_ok   = (wr_idx < IDX_W'(COEF_CNT));
    assign open_req = batch_start && ((state_q == ST_IDLE) || (state_q == ST_LOAD));
    assign batch_wr = (state_q == ST_LOAD) && wr_en && !batch_start && !commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: open, accept, reject, settle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (batch_start) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (batch_start) state_d = ST_LOAD;
                else if (commit) state_d = err_q ? ST_REFUSE : ST_APPLY;
            end
            ST_APPLY:  state_d = ST_IDLE;
            ST_REFUSE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_accept = 1'b0;
        do_apply  = 1'b0;
        unique case (state_q)
            ST_LOAD:  wr_accept = batch_wr && idx_ok && !conv_ovf;
            ST_APPLY: do_apply  = 1'b1;
            default: begin
                wr_accept = 1'b0;
                do_apply  = 1'b0;
            end
        endcase
    end

    // sticky batch error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              err_q <= 1'b0;
        else if (open_req)                       err_q <= 1'b0;
        else if (batch_wr && (!idx_ok || conv_ovf)) err_q <= 1'b1;
    end

    assign err_flag = err_q;

    p_apply_clean_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |-> !err_q);

    p_refuse_err_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFUSE) |-> err_q);

    p_err_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !batch_start) |=> err_q);

    p_err_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        open_req |=> (!err_q && (state_q == ST_LOAD)));

    p_settle_r12 : assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_APPLY) || (state_q == ST_REFUSE)) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ctm_coeff_bank.sv
module ctm_coeff_bank #(
    parameter int unsigned COEF_CNT = 9,
    parameter int unsigned OUT_W    = 15,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_accept,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [OUT_W-1:0]          wr_q,
    input  logic                      do_apply,
    output logic [COEF_CNT*OUT_W-1:0] active_flat
);

    logic [OUT_W-1:0] pending_q [COEF_CNT];
    logic [OUT_W-1:0] active_q  [COEF_CNT];

    for (genvar g = 0; g < COEF_CNT; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                         pending_q[g] <= '0;
            else if (wr_accept && (wr_idx == IDX_W'(g)))        pending_q[g] <= wr_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        active_q[g] <= '0;
            else if (do_apply) active_q[g] <= pending_q[g];
        end

        assign active_flat[g*OUT_W +: OUT_W] = active_q[g];
    end

    p_active_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !do_apply |=> $stable(active_flat));

    p_index_range_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (wr_idx < IDX_W'(COEF_CNT)));

endmodule

// File: rtl/ctm_coeff_loader.sv
module ctm_coeff_loader
    import ctm_pkg::*;
#(
    parameter int unsigned COEF_CNT  = CTM_COEF_CNT,
    parameter int unsigned IN_W      = CTM_IN_W,
    parameter int unsigned OUT_W     = CTM_OUT_W,
    parameter int unsigned DROP_BITS = CTM_DROP_BITS,
    parameter int unsigned IDX_W     = CTM_IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      batch_start,
    input  logic                      commit,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [IN_W-1:0]           wr_data,
    output logic [COEF_CNT*OUT_W-1:0] active_coeffs,
    output logic                      err_flag
);

    logic [OUT_W-1:0] conv_q;
    logic             conv_ovf;
    logic             wr_accept;
    logic             do_apply;

    ctm_q_convert #(
        .IN_W      (IN_W),
        .OUT_W     (OUT_W),
        .DROP_BITS (DROP_BITS)
    ) u_conv (
        .raw   (wr_data),
        .q_val (conv_q),
        .q_ovf (conv_ovf)
    );

    ctm_seq_ctrl #(
        .COEF_CNT (COEF_CNT),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .batch_start (batch_start),
        .commit      (commit),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .conv_ovf    (conv_ovf),
        .wr_accept   (wr_accept),
        .do_apply    (do_apply),
        .err_flag    (err_flag)
    );

    ctm_coeff_bank #(
        .COEF_CNT (COEF_CNT),
        .OUT_W    (OUT_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_accept   (wr_accept),
        .wr_idx      (wr_idx),
        .wr_q        (conv_q),
        .do_apply    (do_apply),
        .active_flat (active_coeffs)
    );

    p_no_overflow_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (wr_data[IN_W-1] == conv_q[OUT_W-1]));

endmodule

// File: tb/ctm_coeff_loader_tb_top.sv
`timescale 1ns/1ps
module ctm_coeff_loader_tb_top;

    localparam int N  = 9;
    localparam int QW = 15;

    typedef struct {
        int                 due;
        logic [N*QW-1:0]    act;
        logic               err;
        string              tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            batch_start = 1'b0;
    logic            commit = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_idx = '0;
    logic [63:0]     wr_data = '0;
    logic [N*QW-1:0] active_coeffs;
    logic            err_flag;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    logic [QW-1:0] m_pend [N];
    logic [QW-1:0] m_act  [N];
    bit m_err = 0, m_open = 0, m_busy = 0, m_apply = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ctm_coeff_loader dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .batch_start   (batch_start),
        .commit        (commit),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .active_coeffs (active_coeffs),
        .err_flag      (err_flag)
    );

    function automatic void ref_conv(input logic [63:0] v, output logic [QW-1:0] q, output bit ok);
        longint unsigned mag;
        int unsigned     c;
        mag = 64'(v[62:0]);
        c   = int'((mag / 64'd1048576) % 64'd32768);
        if (v[63]) c = (32768 - c) % 32768;
        q  = c[QW-1:0];
        ok = (v[63] == c[14]);
    endfunction

    function automatic logic [N*QW-1:0] flat_act();
        logic [N*QW-1:0] f;
        for (int i = 0; i < N; i++) f[i*QW +: QW] = m_act[i];
        return f;
    endfunction

    task automatic step(input bit bs, input bit cm, input bit we,
                        input logic [3:0] idx, input logic [63:0] d, input string tag);
        logic [QW-1:0] q;
        bit            ok;
        exp_t          e;
        batch_start = bs;
        commit      = cm;
        wr_en       = we;
        wr_idx      = idx;
        wr_data     = d;
        if (m_busy) begin
            if (m_apply) for (int i = 0; i < N; i++) m_act[i] = m_pend[i];
            m_busy = 0;
            m_open = 0;
        end else if (bs) begin
            m_open = 1;
            m_err  = 0;
        end else if (m_open && cm) begin
            m_busy  = 1;
            m_apply = !m_err;
            m_open  = 0;
        end else if (m_open && we) begin
            ref_conv(d, q, ok);
            if (idx > 4'd8 || !ok) m_err = 1;
            else m_pend[idx] = q;
        end
        e.due = cyc + 1;
        e.act = flat_act();
        e.err = m_err;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 4'd0, 64'd0, tag);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [63:0] d, input string tag);
        step(0, 0, 1, idx, d, tag);
    endtask

    // monitor: compare queued expectations in the cycle they fall due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (active_coeffs !== e.act || err_flag !== e.err) begin
                errors++;
                $display("FAIL %s: act=%h err=%b expected act=%h err=%b",
                         e.tag, active_coeffs, err_flag, e.act, e.err);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=%h err=%b expected completion", active_coeffs, err_flag);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_pend[i] = '0;
            m_act[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        // R7: write with no open batch
        wr(4'd0, 64'h0000_0001_0000_0000, "R7 write outside batch");
        step(1, 0, 0, 0, 0, "R10 open");
        step(0, 1, 0, 0, 0, "R8 commit");
        idle("R8 apply cycle");
        idle("R7 active still zero");
        // full matrix load
        step(1, 0, 0, 0, 0, "R10 open");
        wr(4'd0, 64'h0000_0001_0000_0000, "R2 +1.0");
        wr(4'd1, 64'h8000_0001_0000_0000, "R3 -1.0");
        wr(4'd2, 64'h8000_0002_0000_0000, "R4 -2.0 accepted");
        wr(4'd3, 64'h0000_0002_0000_0000, "R2 +2.0");
        wr(4'd4, 64'h0000_0000_8008_1234, "R2 truncation");
        wr(4'd5, 64'h0000_0009_0000_0000, "R2 high bits discarded");
        wr(4'd6, 64'h8000_0000_C000_0000, "R3 -0.75");
        wr(4'd7, 64'h0000_0003_FFFF_FFFF, "R2 near max");
        wr(4'd8, 64'h8000_0003_0000_0000, "R3 -3.0");
        step(0, 1, 0, 0, 0, "R8 commit");
        idle("R8 apply cycle");
        idle("R8 bank updated");
        // overflow and refused commit
        step(1, 0, 0, 0, 0, "R10 open");
        wr(4'd1, 64'h0000_0004_0000_0000, "R5 +4.0 overflow");
        wr(4'd2, 64'h8000_0005_0000_0000, "R5 -5.0 overflow");
        step(0, 1, 0, 0, 0, "R9 commit refused");
        idle("R9 refuse cycle");
        idle("R9 active unchanged");
        // bad index
        step(1, 0, 0, 0, 0, "R10 error cleared");
        wr(4'd9, 64'h0000_0001_0000_0000, "R6 index 9");
        wr(4'd15, 64'h0000_0001_0000_0000, "R6 index 15");
        step(0, 1, 0, 0, 0, "R6 commit refused");
        idle("R6 refuse cycle");
        idle("R6 active unchanged");
        // negative with zero candidate
        step(1, 0, 0, 0, 0, "R10 open");
        wr(4'd4, 64'h8000_0000_0000_1000, "R4 negative zero candidate");
        step(0, 1, 0, 0, 0, "R4 commit refused");
        idle("R4 refuse cycle");
        // priorities and busy-cycle ignore
        step(1, 0, 0, 0, 0, "R10 open");
        wr(4'd0, 64'h8000_0004_0000_0000, "R4 -4.0 accepted");
        step(1, 0, 1, 4'd1, 64'h0000_0001_0000_0000, "R11 open drops write");
        step(0, 1, 1, 4'd2, 64'h0000_0001_0000_0000, "R11 commit drops write");
        step(1, 0, 1, 4'd3, 64'h0000_0001_0000_0000, "R12 inputs ignored in apply");
        idle("R12 bank after apply");
        wr(4'd5, 64'h0000_0001_0000_0000, "R12 idle afterwards");
        step(1, 0, 0, 0, 0, "R10 pending retained");
        step(0, 1, 0, 0, 0, "R11 commit");
        idle("R11 apply cycle");
        idle("R11 final bank");
        idle("R12 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule